// File: doc/BRIEF.md
# Buffer-Described SPI Master

This block is an SPI master whose transfers are described entirely by the contents of a shared 512-byte buffer. Software fills the buffer through a byte-wide host port: a two-byte operation header at offsets 0 and 1, with the more significant byte at offset 0, followed by any bytes to send. It then writes a command word. The command holds a start strobe, the index of a timing/mode profile and the index of the peripheral to select.

The engine reads the header and learns three things from it: how many bytes to move, whether the transfer sends, receives or does both, and whether dual-line mode is requested. It then shifts the bytes MSB first. The shift clock advances only on the cycles where an external clock-enable tick is high. Received bytes are written back into the buffer starting at offset 0. Because the engine reads transmit bytes two positions ahead of where it writes received bytes, a full-duplex transfer never overwrites a byte it has not yet sent.

A busy output stays high from the command until the last byte has been stored. Each profile supplies four settings: a fill byte sent during receive-only transfers, a permission bit for dual-line reads, a permission bit for dual-line writes, and a 3-wire setting in which the single data pin is released for receive-only transfers.

Top module: `spi_hb_master`

## Requirements
- R1: A host write (`host_we`) stores `host_wdata` at `host_addr` while the block is idle. `host_rdata` always shows the byte at `host_addr`. Host writes made while busy is high leave the buffer unchanged.
- R2: A `cmd_we` with `cmd_wdata[0]`=1 while idle makes busy high on the next cycle. In that command, bits [10:8] give the profile index and bits [14:12] give the peripheral index. A start strobe while busy is ignored: the selected peripheral does not change and no second transfer follows.
- R3: The header is read as {offset 0, offset 1}. Bits [9:0] give the byte count, bit 11 requests dual mode, and bits [14:13] give the operation: 1 = full duplex, 2 = send only, 3 = receive only.
- R4: Send-only and full-duplex transfers take byte i from offset 2+i and drive it MSB first on `sd_out[0]`, stable at each rising `sclk`. A send-only transfer leaves the buffer unchanged.
- R5: Receive-only and full-duplex transfers sample `sd_in[1]` on each rising `sclk` and store byte i at offset i.
- R6: Receive-only transfers drive the profile fill byte (profile word bits [7:0]) as the outgoing data.
- R7: Dual mode applies only in two cases. With header bit 11 set, a send-only transfer uses it when profile bit 18 is set, and a receive-only transfer uses it when profile bit 16 is set. In dual mode, two bits move per `sclk` with the higher bit on line 1: send drives `sd_out[1:0]` with both enables high, and receive samples `sd_in[1:0]` with both enables low. Full duplex is always single-line.
- R8: With profile bit 20 (3-wire) set, received bits are taken from `sd_in[0]`. A receive-only 3-wire transfer keeps `sd_oe[0]` low.
- R9: A byte count of zero returns busy to low one cycle after it rose, with no `sclk` pulse.
- R10: `sclk` is low whenever idle and changes only on cycles where `sclk_en` is high. Exactly the commanded `cs_n` bit is low while busy, and all bits are high while idle.
- R11: A transfer of n bytes produces 8n rising `sclk` edges in single mode and 4n in dual mode, then busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | 9 | Host buffer byte address |
| host_wdata | input | 8 | Host buffer write byte |
| host_rdata | output | 8 | Buffer byte at host_addr |
| prof_we | input | 1 | Profile word write strobe |
| prof_addr | input | 3 | Profile index to write |
| prof_wdata | input | 32 | Profile word (fill, dual read, dual write, 3-wire) |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command word (start, profile, peripheral) |
| busy | output | 1 | Transfer in progress |
| sclk_en | input | 1 | Shift clock advance tick |
| sclk | output | 1 | SPI clock |
| cs_n | output | 8 | Active-low peripheral selects |
| sd_out | output | 2 | Data line outputs |
| sd_oe | output | 2 | Data line output enables |
| sd_in | input | 2 | Data line inputs |

## Verification
The bench attacks the ordering and boundary cases of this block:
- **Full duplex overlap.** Received bytes overwrite the header area while later send bytes are still being read. A design that read and wrote the same offset would send back its own received data.
- **Mode gating.** Dual mode is requested by the header but permitted by the profile. A design that ignored either side would halve or double the clock count or send the wrong bit pairs.
- **3-wire receive.** Pin release and the source of sampled bits are checked; a design getting this wrong would drive against the peripheral or read the wrong line.
- **Zero count, mid-transfer start, host write during a transfer.** A zero count must produce no clock. A start strobe mid-transfer must not switch the select or queue a second transfer. A host write during a transfer must not corrupt the buffer.

// File: rtl/spi_hb_pkg.sv
package spi_hb_pkg;

  localparam int HDR_BYTES = 2;
  localparam int CNTW      = 10;
  localparam int IDXW      = 3;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_XCHG = 2'd1,
    OP_SEND = 2'd2,
    OP_RECV = 2'd3
  } op_e;

  typedef struct packed {
    logic       three_wire;
    logic       dual_wr;
    logic       dual_rd;
    logic [7:0] fill;
  } prof_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_LOAD,
    ST_SHIFT,
    ST_STORE
  } state_e;

endpackage

// File: rtl/spi_hb_profiles.sv
module spi_hb_profiles
  import spi_hb_pkg::*;
#(
  parameter int NUM_PROF = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [31:0]     wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output prof_t           rd_prof
);

  localparam int SLOTS = 1 << IDXW;

  prof_t table_w [SLOTS];
  prof_t wr_val;
  logic  unused_wr_bits;

  always_comb begin
    wr_val.fill       = wr_data[7:0];
    wr_val.dual_rd    = wr_data[16];
    wr_val.dual_wr    = wr_data[18];
    wr_val.three_wire = wr_data[20];
  end

  assign unused_wr_bits = ^{wr_data[31:21], wr_data[19], wr_data[17], wr_data[15:8]};

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g < NUM_PROF) begin : g_reg
        prof_t q;
        logic  en;
        assign en = wr_en && (wr_idx == IDXW'(g));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            q <= '0;
          end else if (en) begin
            q <= wr_val;
          end
        end
        assign table_w[g] = q;
      end else begin : g_none
        assign table_w[g] = '0;
      end
    end
  endgenerate

  assign rd_prof = table_w[rd_idx];

endmodule

// File: rtl/spi_hb_buf.sv
module spi_hb_buf #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [7:0]    eng_wdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [7:0]    eng_rdata,
  output logic [15:0]   hdr
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (eng_we) begin
      mem[eng_waddr] <= eng_wdata;
    end else if (host_we) begin
      mem[host_addr] <= host_wdata;
    end
  end

  assign host_rdata = mem[host_addr];
  assign eng_rdata  = mem[eng_raddr];
  assign hdr        = {mem[0], mem[1]};

  // Host writes are gated off while the engine owns the buffer.
  assert_no_write_clash_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && eng_we));

endmodule

// File: rtl/spi_hb_engine.sv
module spi_hb_engine
  import spi_hb_pkg::*;
#(
  parameter int AW     = 9,
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDXW-1:0]   cmd_prof,
  input  logic [IDXW-1:0]   cmd_slave,
  input  logic              sclk_en,
  input  logic [15:0]       hdr,
  input  prof_t             prof,
  input  logic [7:0]        buf_rdata,
  input  logic [1:0]        sd_in,
  output logic              busy,
  output logic [IDXW-1:0]   prof_sel,
  output logic [AW-1:0]     buf_raddr,
  output logic              buf_we,
  output logic [AW-1:0]     buf_waddr,
  output logic [7:0]        buf_wdata,
  output logic              sclk,
  output logic [NUM_CS-1:0] cs_n,
  output logic [1:0]        sd_out,
  output logic [1:0]        sd_oe
);

  state_e          state_q, state_d;
  logic [IDXW-1:0] prof_q, prof_d;
  logic [IDXW-1:0] slave_q, slave_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CNTW-1:0] idx_q, idx_d;
  op_e             op_q, op_d;
  logic            dual_q, dual_d;
  logic            tw_q, tw_d;
  logic [7:0]      fill_q, fill_d;
  logic [2:0]      step_q, step_d;
  logic [7:0]      tx_q, tx_d;
  logic [7:0]      rx_q, rx_d;
  logic            sclk_q, sclk_d;

  logic            has_tx, has_rx, run, rx_bit;
  logic [2:0]      last_step;
  op_e             hdr_op;
  logic [CNTW-1:0] hdr_cnt;
  logic            unused_hdr_bits;

  assign hdr_op          = op_e'(hdr[14:13]);
  assign hdr_cnt         = hdr[CNTW-1:0];
  assign unused_hdr_bits = ^{hdr[15], hdr[12], hdr[10]};

  assign has_tx    = (op_q == OP_XCHG) || (op_q == OP_SEND);
  assign has_rx    = (op_q == OP_XCHG) || (op_q == OP_RECV);
  assign last_step = dual_q ? 3'd3 : 3'd7;
  assign rx_bit    = tw_q ? sd_in[0] : sd_in[1];
  assign run       = (state_q == ST_LOAD) || (state_q == ST_SHIFT) || (state_q == ST_STORE);

  // next-state logic
  always_comb begin
    state_d = state_q;
    prof_d  = prof_q;
    slave_d = slave_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    op_d    = op_q;
    dual_d  = dual_q;
    tw_d    = tw_q;
    fill_d  = fill_q;
    step_d  = step_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    sclk_d  = sclk_q;
    buf_we  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_HDR;
          prof_d  = cmd_prof;
          slave_d = cmd_slave;
        end
      end
      ST_HDR: begin
        cnt_d   = hdr_cnt;
        op_d    = hdr_op;
        dual_d  = hdr[11] && (((hdr_op == OP_RECV) && prof.dual_rd) ||
                              ((hdr_op == OP_SEND) && prof.dual_wr));
        tw_d    = prof.three_wire;
        fill_d  = prof.fill;
        idx_d   = '0;
        state_d = (hdr_cnt == '0) ? ST_IDLE : ST_LOAD;
      end
      ST_LOAD: begin
        tx_d    = has_tx ? buf_rdata : fill_q;
        step_d  = '0;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (sclk_en) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rx_d   = dual_q ? {rx_q[5:0], sd_in} : {rx_q[6:0], rx_bit};
          end else begin
            sclk_d = 1'b0;
            if (step_q == last_step) begin
              state_d = ST_STORE;
            end else begin
              step_d = step_q + 3'd1;
              tx_d   = dual_q ? {tx_q[5:0], 2'b00} : {tx_q[6:0], 1'b0};
            end
          end
        end
      end
      ST_STORE: begin
        buf_we = has_rx;
        if (idx_q == cnt_q - CNTW'(1)) begin
          state_d = ST_IDLE;
        end else begin
          idx_d   = idx_q + CNTW'(1);
          state_d = ST_LOAD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      prof_q  <= '0;
      slave_q <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      op_q    <= OP_NONE;
      dual_q  <= 1'b0;
      tw_q    <= 1'b0;
      fill_q  <= '0;
      step_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      prof_q  <= prof_d;
      slave_q <= slave_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      op_q    <= op_d;
      dual_q  <= dual_d;
      tw_q    <= tw_d;
      fill_q  <= fill_d;
      step_q  <= step_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      sclk_q  <= sclk_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign prof_sel  = prof_q;
  assign sclk      = sclk_q;
  assign buf_raddr = AW'(idx_q) + AW'(HDR_BYTES);
  assign buf_waddr = AW'(idx_q);
  assign buf_wdata = rx_q;

  assign sd_out   = !run ? 2'b00 : (dual_q ? tx_q[7:6] : {1'b0, tx_q[7]});
  assign sd_oe[0] = run && !((op_q == OP_RECV) && (dual_q || tw_q));
  assign sd_oe[1] = run && dual_q && (op_q == OP_SEND);

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      assign cs_n[g] = !(busy && (slave_q == IDXW'(g)));
    end
  endgenerate

  assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HDR && hdr_cnt == '0) |=> !busy);

  assert_sclk_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> $past(sclk_en));

  assert_idle_clock_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  assert_select_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n));

  assert_dual_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe[1] |-> sd_oe[0]);

endmodule

// File: rtl/spi_hb_master.sv
module spi_hb_master
  import spi_hb_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int NUM_CS    = 8,
  parameter int NUM_PROF  = 8,
  localparam int AW       = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              prof_we,
  input  logic [IDXW-1:0]   prof_addr,
  input  logic [31:0]       prof_wdata,
  input  logic              cmd_we,
  input  logic [15:0]       cmd_wdata,
  output logic              busy,
  input  logic              sclk_en,
  output logic              sclk,
  output logic [NUM_CS-1:0] cs_n,
  output logic [1:0]        sd_out,
  output logic [1:0]        sd_oe,
  input  logic [1:0]        sd_in
);

  logic            start, host_we_ok;
  logic [IDXW-1:0] prof_sel;
  prof_t           prof;
  logic [15:0]     hdr;
  logic [AW-1:0]   eng_raddr, eng_waddr;
  logic [7:0]      eng_rdata, eng_wdata;
  logic            eng_we;
  logic            unused_cmd_bits;

  assign start           = cmd_we && cmd_wdata[0];
  assign host_we_ok      = host_we && !busy;
  assign unused_cmd_bits = ^{cmd_wdata[15], cmd_wdata[11], cmd_wdata[7:1]};

  spi_hb_profiles #(.NUM_PROF(NUM_PROF)) u_prof (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prof_we),
    .wr_idx  (prof_addr),
    .wr_data (prof_wdata),
    .rd_idx  (prof_sel),
    .rd_prof (prof)
  );

  spi_hb_buf #(.DEPTH(BUF_BYTES), .AW(AW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we_ok),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .eng_we     (eng_we),
    .eng_waddr  (eng_waddr),
    .eng_wdata  (eng_wdata),
    .eng_raddr  (eng_raddr),
    .eng_rdata  (eng_rdata),
    .hdr        (hdr)
  );

  spi_hb_engine #(.AW(AW), .NUM_CS(NUM_CS)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_prof  (cmd_wdata[10:8]),
    .cmd_slave (cmd_wdata[14:12]),
    .sclk_en   (sclk_en),
    .hdr       (hdr),
    .prof      (prof),
    .buf_rdata (eng_rdata),
    .sd_in     (sd_in),
    .busy      (busy),
    .prof_sel  (prof_sel),
    .buf_raddr (eng_raddr),
    .buf_we    (eng_we),
    .buf_waddr (eng_waddr),
    .buf_wdata (eng_wdata),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sd_out    (sd_out),
    .sd_oe     (sd_oe)
  );

endmodule

// File: tb/spi_hb_master_tb_top.sv
module spi_hb_master_tb_top;

  logic        clk, rst_n;
  logic        host_we;
  logic [8:0]  host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic        prof_we;
  logic [2:0]  prof_addr;
  logic [31:0] prof_wdata;
  logic        cmd_we;
  logic [15:0] cmd_wdata;
  logic        busy, sclk_en, sclk;
  logic [7:0]  cs_n;
  logic [1:0]  sd_out, sd_oe, sd_in;

  int checks = 0;
  int errors = 0;

  spi_hb_master dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .prof_we(prof_we), .prof_addr(prof_addr), .prof_wdata(prof_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .busy(busy),
    .sclk_en(sclk_en), .sclk(sclk), .cs_n(cs_n),
    .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // sclk_en: one tick every second clock
  logic tick_ph = 1'b0;
  always @(negedge clk) begin
    tick_ph = ~tick_ph;
    sclk_en = tick_ph;
  end

  function automatic logic [7:0] txpat(int i);
    return 8'h3C ^ 8'(i * 37);
  endfunction

  function automatic logic [7:0] resp_f(int i);
    return 8'h96 ^ 8'(i * 29);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // peripheral model
  logic       tb_dual = 1'b0;
  logic       tb_tw   = 1'b0;
  int         in_pos  = 0;
  int         rise_cnt = 0;
  int         cap_bits = 0;
  logic [7:0] cap_sh = '0;
  logic [7:0] capq [$];
  logic [7:0] sd_rb;
  int         sd_o;

  always @(posedge sclk) begin
    if (tb_dual) begin
      cap_sh = {cap_sh[5:0], sd_out};
      cap_bits += 2;
    end else begin
      cap_sh = {cap_sh[6:0], sd_out[0]};
      cap_bits += 1;
    end
    if (cap_bits == 8) begin
      capq.push_back(cap_sh);
      cap_bits = 0;
    end
    rise_cnt++;
    in_pos += tb_dual ? 2 : 1;
  end

  always @* begin
    sd_rb = resp_f(in_pos / 8);
    sd_o  = 7 - (in_pos % 8);
    if (tb_dual)    sd_in = {sd_rb[sd_o], sd_rb[(sd_o > 0) ? sd_o - 1 : 0]};
    else if (tb_tw) sd_in = {1'b0, sd_rb[sd_o]};
    else            sd_in = {sd_rb[sd_o], 1'b0};
  end

  // every-clock reference comparison (R10, R8, R7)
  int         cur_slave = 0;
  logic [1:0] exp_oe = 2'b01;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] exp_cs;
      exp_cs = busy ? ~(8'd1 << cur_slave) : 8'hFF;
      chk(cs_n == exp_cs, "R10 select", 32'(cs_n), 32'(exp_cs));
      if (!busy) begin
        chk(sclk == 1'b0, "R10 idle sclk", 32'(sclk), 0);
        chk(sd_oe == 2'b00, "R10 idle oe", 32'(sd_oe), 0);
      end else if (sclk) begin
        chk(sd_oe == exp_oe, "R7/R8 oe", 32'(sd_oe), 32'(exp_oe));
      end
    end
  end

  task automatic buf_wr(int a, logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 9'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic buf_chk(int a, logic [7:0] e, string tag);
    @(negedge clk);
    host_addr = 9'(a);
    #1;
    chk(host_rdata == e, tag, 32'(host_rdata), 32'(e));
  endtask

  task automatic set_prof(int idx, logic [7:0] fill, bit drd, bit dwr, bit tw);
    logic [31:0] w;
    w = '0; w[7:0] = fill; w[16] = drd; w[18] = dwr; w[20] = tw;
    @(negedge clk);
    prof_we = 1'b1; prof_addr = 3'(idx); prof_wdata = w;
    @(negedge clk);
    prof_we = 1'b0;
  endtask

  task automatic issue(int prof, int slave);
    logic [15:0] w;
    w = '0; w[0] = 1'b1; w[10:8] = 3'(prof); w[14:12] = 3'(slave);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_idle(string tag);
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, {tag, " R11 busy clears"}, 32'(busy), 0);
  endtask

  // op: 1 xchg, 2 send, 3 recv
  task automatic xfer(string tag, int prof, int slave, int op, bit mbit, int n,
                      bit dual, bit tw, logic [1:0] oe, logic [7:0] fill, bit disturb);
    logic [15:0] h;
    bit tx_op, rx_op;
    h = '0; h[9:0] = 10'(n); h[11] = mbit; h[14:13] = 2'(op);
    tx_op = (op == 1) || (op == 2);
    rx_op = (op == 1) || (op == 3);
    buf_wr(0, h[15:8]);
    buf_wr(1, h[7:0]);
    for (int i = 0; i < n; i++) buf_wr(2 + i, txpat(i));
    if (disturb) buf_wr(300, 8'h11);
    capq.delete();
    cap_bits = 0; in_pos = 0; rise_cnt = 0;
    tb_dual = dual; tb_tw = tw; exp_oe = oe; cur_slave = slave;
    issue(prof, slave);
    chk(busy == 1'b1, {tag, " R2 busy after start"}, 32'(busy), 1);
    if (disturb) begin
      repeat (4) @(negedge clk);
      issue(prof, 5);
      buf_wr(300, 8'h77);
    end
    wait_idle(tag);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, {tag, " R2 no second transfer"}, 32'(busy), 0);
    chk(rise_cnt == (dual ? 4 * n : 8 * n), {tag, " R11 clock count"}, 32'(rise_cnt),
        32'(dual ? 4 * n : 8 * n));
    chk(capq.size() == n, {tag, " R4 byte count"}, 32'(capq.size()), 32'(n));
    for (int i = 0; i < n && i < capq.size(); i++) begin
      logic [7:0] e;
      e = tx_op ? txpat(i) : fill;
      chk(capq[i] == e, {tag, tx_op ? " R4 sent byte" : " R6 fill byte"}, 32'(capq[i]), 32'(e));
    end
    if (rx_op) begin
      for (int i = 0; i < n; i++) buf_chk(i, resp_f(i), {tag, " R5 stored byte"});
    end else begin
      buf_chk(0, h[15:8], {tag, " R4 header kept"});
      buf_chk(1, h[7:0], {tag, " R4 header kept"});
      for (int i = 0; i < n; i++) buf_chk(2 + i, txpat(i), {tag, " R4 payload kept"});
    end
    if (disturb) buf_chk(300, 8'h11, {tag, " R1 write while busy ignored"});
  endtask

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    prof_we = 1'b0; prof_addr = '0; prof_wdata = '0;
    cmd_we = 1'b0; cmd_wdata = '0; sclk_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 reset busy", 32'(busy), 0);
    chk(cs_n == 8'hFF, "R10 reset select", 32'(cs_n), 32'hFF);
    chk(sclk == 1'b0, "R10 reset sclk", 32'(sclk), 0);
    rst_n = 1'b1;
    @(negedge clk);

    buf_wr(17, 8'h5A);
    buf_wr(511, 8'hC3);
    buf_chk(17, 8'h5A, "R1 readback");
    buf_chk(511, 8'hC3, "R1 readback top");

    set_prof(0, 8'hA5, 0, 0, 0);
    set_prof(1, 8'h00, 1, 1, 0);
    set_prof(2, 8'h3C, 0, 0, 1);
    set_prof(3, 8'hFF, 0, 0, 0);

    xfer("T1 send R3",       0, 2, 2, 0, 3, 0, 0, 2'b01, 8'hA5, 0);
    xfer("T2 recv R6",       0, 0, 3, 0, 2, 0, 0, 2'b01, 8'hA5, 0);
    xfer("T3 xchg R5",       1, 7, 1, 1, 4, 0, 0, 2'b01, 8'h00, 0);
    xfer("T4 dual send R7",  1, 3, 2, 1, 2, 1, 0, 2'b11, 8'h00, 0);
    xfer("T5 dual recv R7",  1, 1, 3, 1, 3, 1, 0, 2'b00, 8'h00, 0);
    xfer("T6 no dual R7",    3, 4, 3, 1, 2, 0, 0, 2'b01, 8'hFF, 0);
    xfer("T7 3wire recv R8", 2, 6, 3, 0, 2, 0, 1, 2'b00, 8'h3C, 0);
    xfer("T8 3wire send R8", 2, 6, 2, 0, 1, 0, 1, 2'b01, 8'h3C, 0);
    xfer("T9 zero R9",       0, 2, 2, 0, 0, 0, 0, 2'b01, 8'hA5, 0);
    xfer("T10 busy R2",      0, 1, 2, 0, 2, 0, 0, 2'b01, 8'hA5, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule